// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Target

This block is an I2C target that gives a bus master byte-level access to a memory of 131,072 eight-bit locations. SCL and SDA are sampled with a fast system clock through a short synchronizer. START and STOP are recognised in any state. The target drives SDA only as an active-high pull-down enable, so the bus line is the wired-AND of every driver.

A transfer opens with an address word. Its upper four bits hold a fixed type code. The next two bits are checked against two strap inputs. The seventh bit is bit 16 of the memory address and the last bit picks read or write. In write mode the master sends two address bytes and then any number of data bytes. Each data byte is stored as soon as its acknowledge ends, and the address then moves up by one and wraps from the top of the array to zero.

In read mode, data is sent from an address kept from the last transfer, or from an address the master has just set and followed with a repeated START. The master acknowledges each byte to get the next one. A write-protect input blocks stores but not reads. The memory itself sits outside the block, on a plain synchronous port with one cycle of read latency.

Top module: `i2c_mem_target`

## Requirements
- R1: While reset is high and on the first cycle after it, SDA is released and no memory read or write strobe is asserted.
- R2: The address word is taken MSB first. Bits 7:4 must equal 1010 and bits 3:2 must equal {strap_sel[1], strap_sel[0]}. Bit 1 is memory address bit 16 and bit 0 selects read (1) or write (0). On any mismatch the target does not acknowledge and ignores the bus until the next START.
- R3: After an acknowledged write-mode address word, the target acknowledges a high byte and then a low byte. Together with bit 16 of the address word they form the 17-bit memory address.
- R4: Each data byte that follows is acknowledged and written at the current address, and the address then increments. After 1FFFFh the next write goes to 00000h.
- R5: While wr_prot is high, data bytes are still acknowledged and the address still advances, but no write strobe is issued. Reads work normally.
- R6: A read-mode address word right after START sends data from {bit 16 of the word, stored low 16 bits} + 1, wrapping at 2^17. The stored low 16 bits belong to the last byte written or sent. After reset, or when an address was set but no data byte followed, the +1 is left out. After reset the stored value is 0.
- R7: A random read (address bytes written, repeated START, then a read-mode address word) sends data from the written address first.
- R8: During a read, a master ACK on the ninth bit makes the target send the next byte, wrapping from 1FFFFh to 00000h. A master NACK makes it release SDA and stay silent until START or STOP.
- R9: A STOP that arrives partway through a data byte, before its acknowledge, drops that byte: nothing is written.
- R10: A START in the middle of any transfer restarts address-word reception, and the partly sent address bytes are discarded.
- R11: Received bits are taken on SCL rising edges. The SDA drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Pull SDA low when high |
| strap_sel | input | 2 | Device-select straps, bit 1 matches address-word bit 3 |
| wr_prot | input | 1 | Write protect, blocks stores when high |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Memory write strobe, one cycle |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read strobe, one cycle |
| mem_rdata | input | 8 | Memory read data, valid the cycle after mem_re |

## Verification
The bench goes after the address edge cases. A page write and a sequential read both cross 1FFFFh, so a counter that saturates, or that carries into the wrong bit, shows up as a wrong store address or a wrong byte sent back. Current-address reads are run after reset, after a read that stopped on a NACK, and with a different bit 16 in the address word. A target that forgets the stored address, adds one when it should not, or ignores the new bit 16 returns the wrong byte. Further cases cover write protect, a STOP partway through a byte, a repeated START after one address byte, and extra clocks after a NACK. A target that stores anyway, commits a partial byte, keeps stale address bytes or keeps driving the line fails the store-log comparison or the line check.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_HOLD
  } tgt_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else if (g == 0) begin
          scl_pipe[g] <= scl_i;
          sda_pipe[g] <= sda_i;
        end else begin
          scl_pipe[g] <= scl_pipe[(g == 0) ? 0 : g-1];
          sda_pipe[g] <= sda_pipe[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cm_addr_ctr.sv
module i2cm_addr_ctr #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          resume_i,
  input  logic          resume_msb_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] work;
  logic [AW-2:0] last;
  logic          fresh;

  always_ff @(posedge clk) begin
    if (rst) begin
      work  <= '0;
      last  <= '0;
      fresh <= 1'b1;
    end else if (load_i) begin
      work  <= load_addr_i;
      last  <= load_addr_i[AW-2:0];
      fresh <= 1'b1;
    end else if (resume_i) begin
      work  <= {resume_msb_i, last} + (fresh ? AW'(0) : AW'(1));
    end else if (step_i) begin
      last  <= work[AW-2:0];
      work  <= work + AW'(1);
      fresh <= 1'b0;
    end
  end

  assign addr_o = work;
endmodule

// File: rtl/i2cm_target_ctrl.sv
module i2cm_target_ctrl
  import i2cm_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic          sda_s,
  input  logic [1:0]    strap_sel,
  input  logic          wr_prot,
  input  logic [AW-1:0] cur_addr,
  output logic          ld_en,
  output logic [AW-1:0] ld_addr,
  output logic          rs_en,
  output logic          rs_msb,
  output logic          step_en,
  output logic          sda_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata
);
  localparam int CNT_W = $clog2(DW + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(DW + 1);

  tgt_state_e       state;
  logic [CNT_W-1:0] bitcnt;
  logic [DW-1:0]    rx, tx, hi_byte, rbuf;
  logic             msb_q, rd_cap;
  logic [1:0]       rd_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;  bitcnt <= '0;
      rx <= '0; tx <= '0; hi_byte <= '0; rbuf <= '0;
      msb_q <= 1'b0; rd_cap <= 1'b0; rd_pend <= '0;
      sda_oe <= 1'b0; mem_we <= 1'b0; mem_re <= 1'b0;
      mem_addr <= '0; mem_wdata <= '0;
      ld_en <= 1'b0; ld_addr <= '0; rs_en <= 1'b0; rs_msb <= 1'b0; step_en <= 1'b0;
    end else begin
      ld_en   <= 1'b0;
      rs_en   <= 1'b0;
      step_en <= 1'b0;
      mem_we  <= 1'b0;
      rd_pend <= {rd_pend[0], 1'b0};
      mem_re  <= rd_pend[1];
      if (rd_pend[1]) mem_addr <= cur_addr;
      rd_cap  <= mem_re;
      if (rd_cap) rbuf <= mem_rdata;

      if (start_p) begin
        state  <= ST_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_p) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
            if (scl_rise) begin
              if (bitcnt < LAST_BIT) rx <= {rx[DW-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              if (state == ST_DEV) begin
                if (rx[DW-1:DW-4] == DEV_TYPE && rx[3:2] == strap_sel) begin
                  sda_oe <= 1'b1;
                  msb_q  <= rx[1];
                  if (rx[0]) begin
                    rs_en   <= 1'b1;
                    rs_msb  <= rx[1];
                    rd_pend <= {rd_pend[0], 1'b1};
                  end
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
              end
            end else if (scl_fall && bitcnt == ACK_BIT) begin
              bitcnt <= '0;
              sda_oe <= 1'b0;
              case (state)
                ST_DEV: begin
                  if (rx[0]) begin
                    state   <= ST_RDAT;
                    tx      <= rbuf;
                    sda_oe  <= ~rbuf[DW-1];
                    step_en <= 1'b1;
                  end else begin
                    state <= ST_AHI;
                  end
                end
                ST_AHI: begin
                  hi_byte <= rx;
                  state   <= ST_ALO;
                end
                ST_ALO: begin
                  ld_en   <= 1'b1;
                  ld_addr <= {msb_q, hi_byte, rx};
                  state   <= ST_WDAT;
                end
                default: begin
                  mem_we    <= ~wr_prot;
                  mem_addr  <= cur_addr;
                  mem_wdata <= rx;
                  step_en   <= 1'b1;
                end
              endcase
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              if (bitcnt == LAST_BIT) begin
                if (sda_s) begin
                  state <= ST_HOLD;
                end else begin
                  bitcnt  <= ACK_BIT;
                  rd_pend <= {rd_pend[0], 1'b1};
                end
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end else if (scl_fall) begin
              if (bitcnt == ACK_BIT) begin
                tx      <= rbuf;
                sda_oe  <= ~rbuf[DW-1];
                step_en <= 1'b1;
                bitcnt  <= '0;
              end else if (bitcnt == LAST_BIT) begin
                sda_oe <= 1'b0;
              end else if (bitcnt != '0) begin
                tx     <= {tx[DW-2:0], 1'b0};
                sda_oe <= ~tx[DW-2];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int ADDR_W      = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        strap_sel,
  input  logic              wr_prot,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata
);
  logic sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic ld_en, rs_en, rs_msb, step_en;
  logic [ADDR_W-1:0] ld_addr, cur_addr;

  i2cm_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  i2cm_addr_ctr #(.AW(ADDR_W)) u_ctr (
    .clk(clk), .rst(rst), .load_i(ld_en), .load_addr_i(ld_addr),
    .resume_i(rs_en), .resume_msb_i(rs_msb), .step_i(step_en),
    .addr_o(cur_addr)
  );

  i2cm_target_ctrl #(.AW(ADDR_W), .DW(8)) u_ctrl (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .sda_s(sda_s),
    .strap_sel(strap_sel), .wr_prot(wr_prot), .cur_addr(cur_addr),
    .ld_en(ld_en), .ld_addr(ld_addr), .rs_en(rs_en), .rs_msb(rs_msb),
    .step_en(step_en), .sda_oe(sda_oe), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
    .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          sda_i,
  input logic          sda_oe,
  input logic          wr_prot,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr
);
  logic          scl_p, sda_p, have_we;
  logic [AW-1:0] last_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p   <= 1'b1;
      sda_p   <= 1'b1;
      have_we <= 1'b0;
      last_we <= '0;
    end else begin
      scl_p <= scl_i;
      sda_p <= sda_i;
      if (scl_i && scl_p && sda_p && !sda_i) begin
        have_we <= 1'b0;
      end else if (mem_we) begin
        have_we <= 1'b1;
        last_we <= mem_addr;
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!sda_oe && !mem_we && !mem_re)) else $error("reset quiet"); // R1
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (rst) (mem_we && have_we) |-> (mem_addr == last_we + AW'(1))) else $error("page step"); // R4
  AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (rst) !(mem_we && mem_re)) else $error("rw clash"); // R4
  AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (rst) mem_we |-> !wr_prot) else $error("write under protect"); // R5
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst) !$stable(sda_oe) |-> !scl_i) else $error("sda moved with scl high"); // R11
endmodule

bind i2c_mem_target i2cm_checker #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
  .wr_prot(wr_prot), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr)
);

// File: tb/tb_i2c_mem_target.sv
module tb_i2c_mem_target;
  localparam int Q = 4;
  localparam logic [1:0] STRAP = 2'b10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic sda_oe, mem_we, mem_re;
  logic [16:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  wire sda_bus = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  i2c_mem_target dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_sel(STRAP), .wr_prot(wp), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit [7:0] dmem [int];
  bit [7:0] ref_mem [int];
  int ref_last = 0;
  bit ref_fresh = 1'b1;
  int wq_addr[$], exp_addr[$];
  bit [7:0] wq_data[$], exp_data[$];
  logic oe_prev = 1'b0;

  // bench-side memory, one cycle read latency
  always @(posedge clk) begin
    if (mem_we) begin
      dmem[int'(mem_addr)] = mem_wdata;
      wq_addr.push_back(int'(mem_addr));
      wq_data.push_back(mem_wdata);
    end
    if (mem_re) mem_rdata <= dmem.exists(int'(mem_addr)) ? dmem[int'(mem_addr)] : 8'h00;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // per-clock checks: line only moves with SCL low (R11), no store under protect (R5)
  always @(negedge clk) begin
    if (!rst) begin
      if (sda_oe !== oe_prev) chk(!m_scl, "R11", int'(m_scl), 0);
      if (mem_we) chk(!wp, "R5", int'(wp), 0);
    end
    oe_prev = sda_oe;
  end

  function automatic bit [7:0] ref_rd(int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  task automatic half(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start;
    m_sda = 1'b1; half(Q); m_scl = 1'b1; half(Q);
    m_sda = 1'b0; half(Q); m_scl = 1'b0; half(Q);
  endtask

  task automatic m_stop;
    m_sda = 1'b0; half(Q); m_scl = 1'b1; half(Q); m_sda = 1'b1; half(Q);
  endtask

  task automatic m_bit_out(bit b);
    m_sda = b; half(Q); m_scl = 1'b1; half(2*Q); m_scl = 1'b0; half(Q);
  endtask

  task automatic m_send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) m_bit_out(b[i]);
    m_sda = 1'b1; half(Q); m_scl = 1'b1; half(Q);
    ack = !sda_bus;
    half(Q); m_scl = 1'b0; half(Q);
  endtask

  task automatic m_recv(output logic [7:0] b, input bit give_ack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      half(Q); m_scl = 1'b1; half(Q);
      b[i] = sda_bus;
      half(Q); m_scl = 1'b0;
    end
    half(Q); m_sda = !give_ack; half(Q);
    m_scl = 1'b1; half(2*Q); m_scl = 1'b0; half(1);
    m_sda = 1'b1; half(Q-1);
  endtask

  task automatic check_writes(string req);
    half(4);
    chk(wq_addr.size() == exp_addr.size(), req, wq_addr.size(), exp_addr.size());
    for (int i = 0; i < exp_addr.size() && i < wq_addr.size(); i++) begin
      chk(wq_addr[i] == exp_addr[i], req, wq_addr[i], exp_addr[i]);
      chk(wq_data[i] == exp_data[i], req, wq_data[i], exp_data[i]);
    end
    wq_addr.delete(); wq_data.delete(); exp_addr.delete(); exp_data.delete();
  endtask

  task automatic send_addr(int addr);
    bit a;
    m_send({4'b1010, STRAP, addr[16], 1'b0}, a); chk(a, "R2", a, 1);
    m_send(addr[15:8], a); chk(a, "R3", a, 1);
    m_send(addr[7:0], a);  chk(a, "R3", a, 1);
    ref_last = addr & 32'hFFFF; ref_fresh = 1'b1;
  endtask

  task automatic do_write(int addr, bit [7:0] d[$], string req);
    bit a;
    int cur = addr;
    m_start;
    send_addr(addr);
    foreach (d[i]) begin
      m_send(d[i], a); chk(a, req, a, 1);
      if (!wp) begin
        exp_addr.push_back(cur); exp_data.push_back(d[i]); ref_mem[cur] = d[i];
      end
      ref_last = cur & 32'hFFFF; ref_fresh = 1'b0;
      cur = (cur + 1) & 32'h1FFFF;
    end
    m_stop;
    check_writes(req);
  endtask

  task automatic read_bytes(int start, int n, string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      int a = (start + i) & 32'h1FFFF;
      m_recv(b, i != n - 1);
      chk(b == ref_rd(a), req, b, ref_rd(a));
      ref_last = a & 32'hFFFF; ref_fresh = 1'b0;
    end
  endtask

  task automatic do_rand_read(int addr, int n, string req);
    bit a;
    m_start;
    send_addr(addr);
    m_start;
    m_send({4'b1010, STRAP, addr[16], 1'b1}, a); chk(a, "R7", a, 1);
    read_bytes(addr, n, req);
    m_stop;
  endtask

  task automatic do_cur_read(bit b16, int n, string req, bit probe);
    bit a;
    int start = (((int'(b16) << 16) | ref_last) + (ref_fresh ? 0 : 1)) & 32'h1FFFF;
    m_start;
    m_send({4'b1010, STRAP, b16, 1'b1}, a); chk(a, req, a, 1);
    read_bytes(start, n, req);
    if (probe) begin
      for (int i = 0; i < 9; i++) begin
        m_bit_out(1'b1);
        chk(sda_bus == 1'b1, "R8", sda_bus, 1);
      end
    end
    m_stop;
  endtask

  initial begin
    bit a;
    bit [7:0] d[$];
    dmem[0] = 8'h3C; ref_mem[0] = 8'h3C;
    dmem[32'h10003] = 8'hC7; ref_mem[32'h10003] = 8'hC7;
    half(3);
    chk(sda_oe == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R1", {sda_oe, mem_we, mem_re}, 0);
    half(3); rst = 1'b0; half(1);
    chk(sda_oe == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R1", {sda_oe, mem_we, mem_re}, 0);
    chk(sda_bus == 1'b1, "R1", sda_bus, 1);
    half(4);

    // R6: right after reset the stored address is 0 and is used as is
    do_cur_read(1'b0, 1, "R6", 1'b0);

    // R2: wrong type code, then wrong straps
    m_start;
    m_send(8'hB4, a); chk(!a, "R2", a, 0);
    m_send(8'hA8, a); chk(!a, "R2", a, 0);
    m_stop;
    m_start;
    m_send(8'hA4, a); chk(!a, "R2", a, 0);
    m_stop;
    check_writes("R2");

    // R3/R4: two-byte write with bit 16 set
    d = '{8'hA5, 8'h5A};
    do_write(32'h12345, d, "R4");

    // R4: page write across the top of the array
    d = '{8'h11, 8'h22, 8'h33, 8'h44};
    do_write(32'h1FFFE, d, "R4");

    // R7/R8: random then sequential read across the wrap
    do_rand_read(32'h1FFFE, 3, "R8");

    // R6: continue from last sent + 1, then new bit 16 from the word
    do_cur_read(1'b0, 2, "R6", 1'b0);
    do_cur_read(1'b1, 1, "R6", 1'b0);

    // R5: protected write is acked, not stored; read still works
    wp = 1'b1;
    d = '{8'h77};
    do_write(32'h00010, d, "R5");
    do_rand_read(32'h00010, 1, "R5");
    wp = 1'b0;

    // R9: STOP partway through a data byte
    m_start;
    send_addr(32'h12345);
    for (int i = 0; i < 4; i++) m_bit_out(1'b0);
    m_stop;
    check_writes("R9");
    do_cur_read(1'b1, 1, "R9", 1'b0);

    // R10: repeated START after only the high address byte
    m_start;
    m_send({4'b1010, STRAP, 1'b0, 1'b0}, a); chk(a, "R10", a, 1);
    m_send(8'h55, a); chk(a, "R10", a, 1);
    do_cur_read(1'b1, 1, "R10", 1'b0);

    // R8: after NACK the line stays released
    do_cur_read(1'b0, 1, "R8", 1'b1);
    check_writes("R10");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule